// File: doc/BRIEF.md
# Dual-Channel Converter Power Mode Sequencer

This block sits beside a two-channel data converter and turns its raw power controls into a clean per-channel status. A chip-wide power-down input (active low) and a per-channel run-request bus (`slp_n`, one bit per channel, 1 = run) are decoded every clock into one of four channel states: `CH_OFF` (power-down), `CH_SLEEP` (idle, references kept warm), `CH_WAKE` (start-up count running) and `CH_ACTIVE` (samples usable). Each channel has its own start-up counter. A channel's data-valid output stays low until its wake time and the fixed conversion pipeline latency have both run out. A zero-force output tells the data path to clamp the channel's data bus to zero while the chip is powered down.

Power-down overrides every other control. Leaving power-down needs a long wake time, because references must settle. Leaving sleep needs a short one. After reset the block refuses to leave `CH_OFF` until it has seen power-down applied at least once. Per-channel output-enable inputs (active low) pass straight through as driver enables for the tristate pads.

Per-channel transitions, evaluated at each clock edge:
- `PD_ENTER`: any state goes to `CH_OFF` when `pd_n` = 0.
- `HOLD_UNARMED`: the channel stays in `CH_OFF` while power-down has not yet been seen.
- `IDLE_ENTER`: `CH_OFF` goes to `CH_SLEEP` when the request bit is 0.
- `WAKE_START`: `CH_OFF` or `CH_SLEEP` goes to `CH_WAKE` when the request bit is 1.
- `WAKE_ABORT`: `CH_WAKE` goes to `CH_SLEEP` when the request bit is 0.
- `WAKE_DONE`: `CH_WAKE` goes to `CH_ACTIVE` when the count expires.
- `RUN_STOP`: `CH_ACTIVE` goes to `CH_SLEEP` when the request bit is 0.

Top module: `adc_pwr_seq`

## Requirements
- R1: At any clock edge where `pd_n` = 0, every channel enters `CH_OFF`, whatever `slp_n` and the current state are. After that edge `data_valid` is 0 and `zero_force` is 1 for all channels.
- R2: `zero_force[i]` is 1 exactly when channel i is in `CH_OFF`. It is 0 in `CH_SLEEP`, `CH_WAKE` and `CH_ACTIVE`.
- R3: Bit i of `slp_n` requests channel i to run (1) or sleep (0). So 00 sleeps both channels, 01 runs only channel 0, 10 runs only channel 1 and 11 runs both.
- R4: A cold channel starts waking at an edge E. A channel is cold if it has been in `CH_OFF` and has not reached `CH_ACTIVE` since. Its `data_valid` rises after edge E+912, which is 900 wake cycles plus 12 pipeline cycles, provided the request holds and `pd_n` stays 1.
- R5: A warm channel starts waking at edge E. Its `data_valid` rises after edge E+32, which is 20 wake cycles plus 12 pipeline cycles.
- R6: A channel that moved from `CH_OFF` to `CH_SLEEP` without running stays cold. Its next wake takes the long count of R4.
- R7: If a waking channel's request bit is 0 at an edge, the wake aborts: the channel enters `CH_SLEEP` with `data_valid` 0. The next request restarts the count in full.
- R8: After reset, no channel leaves `CH_OFF` and no `data_valid` is asserted until `pd_n` has been sampled 0 at least once.
- R9: Each channel has its own counter. Waking or sleeping one channel leaves the other channel's `data_valid` unchanged.
- R10: `drv_en[i]` is the inverse of `oe_n[i]` in every state, combinationally. 1 means the data pads are driven; 0 means they are tristate.
- R11: If an active channel's request bit is 0 at an edge, the channel enters `CH_SLEEP` and `data_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high; returns to the unarmed state |
| pd_n | input | 1 | Chip power-down, active low; overrides all other controls |
| slp_n | input | NUM_CH | Per-channel run request, 1 = run, 0 = sleep |
| oe_n | input | NUM_CH | Per-channel output enable, active low |
| drv_en | output | NUM_CH | Pad driver enable per channel, 1 = drive, 0 = tristate |
| data_valid | output | NUM_CH | Channel data usable |
| zero_force | output | NUM_CH | Clamp channel data to zero (power-down) |

## Verification
A wrong internal state shows at the ports within one edge in most cases. A channel stuck outside `CH_OFF` leaves `zero_force` low when it should be high. A missed abort or stop keeps `data_valid` high after the request bit drops. Errors in the counter or in the cold/warm choice appear only when the wake ends, up to 912 edges later, as a `data_valid` rise at the wrong cycle. For that reason the bench predicts the exact rise edge for every wake. It covers cold and warm wakes, aborts, and one channel waking while the other runs.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_SLEEP  = 2'd1,
        CH_WAKE   = 2'd2,
        CH_ACTIVE = 2'd3
    } ch_state_e;
endpackage

// File: rtl/adc_pwr_arm.sv
// Tracks whether power-down has been seen since reset.
module adc_pwr_arm (
    input  logic clk,
    input  logic rst,
    input  logic pd_n,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (!pd_n)
            armed <= 1'b1;
    end

    // Once armed, only reset can clear it.
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed); // R8
endmodule

// File: rtl/adc_pwr_chan.sv
// One channel: state register, wake counter, cold flag.
module adc_pwr_chan
    import adc_pwr_pkg::*;
#(
    parameter int COLD_CYC = 900,
    parameter int WARM_CYC = 20,
    parameter int PIPE_CYC = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pd_n,
    input  logic      armed,
    input  logic      want,
    output ch_state_e state,
    output logic      valid,
    output logic      zero_force
);
    localparam int COLD_TOTAL = COLD_CYC + PIPE_CYC;
    localparam int WARM_TOTAL = WARM_CYC + PIPE_CYC;
    localparam int CNT_W      = $clog2(COLD_TOTAL + 1);
    localparam logic [CNT_W-1:0] COLD_LOAD = CNT_W'(COLD_TOTAL - 1);
    localparam logic [CNT_W-1:0] WARM_LOAD = CNT_W'(WARM_TOTAL - 1);

    ch_state_e        state_d;
    logic [CNT_W-1:0] cnt, cnt_d;
    logic             cold, cold_d;

    // Next state and counter.
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        cold_d  = cold;
        if (!pd_n) begin                       // PD_ENTER
            state_d = CH_OFF;
            cnt_d   = '0;
            cold_d  = 1'b1;
        end else if (!armed) begin             // HOLD_UNARMED
            state_d = CH_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state)
                CH_OFF, CH_SLEEP: begin
                    if (want) begin            // WAKE_START
                        state_d = CH_WAKE;
                        cnt_d   = cold ? COLD_LOAD : WARM_LOAD;
                    end else begin             // IDLE_ENTER
                        state_d = CH_SLEEP;
                    end
                end
                CH_WAKE: begin
                    if (!want) begin           // WAKE_ABORT
                        state_d = CH_SLEEP;
                        cnt_d   = '0;
                    end else if (cnt == '0) begin  // WAKE_DONE
                        state_d = CH_ACTIVE;
                        cold_d  = 1'b0;
                    end else begin
                        cnt_d = cnt - 1'b1;
                    end
                end
                CH_ACTIVE: begin
                    if (!want)                 // RUN_STOP
                        state_d = CH_SLEEP;
                end
                default: state_d = CH_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_OFF;
            cnt   <= '0;
            cold  <= 1'b1;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            cold  <= cold_d;
        end
    end

    // Outputs.
    always_comb begin
        valid      = (state == CH_ACTIVE);
        zero_force = (state == CH_OFF);
    end

    AST_PD_TO_OFF: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> (state == CH_OFF)); // R1
    AST_ABORT_TO_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (pd_n && armed && state == CH_WAKE && !want) |=> (state == CH_SLEEP && !valid)); // R7
    AST_VALID_AFTER_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(state == CH_WAKE && cnt == '0)); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= COLD_LOAD); // R5
    AST_SLEEP_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (pd_n && armed && !want) |=> !valid); // R11
endmodule

// File: rtl/adc_pwr_seq.sv
// Top: arming flag plus one sequencer per channel.
module adc_pwr_seq #(
    parameter int NUM_CH   = 2,
    parameter int COLD_CYC = 900,
    parameter int WARM_CYC = 20,
    parameter int PIPE_CYC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic [NUM_CH-1:0] slp_n,
    input  logic [NUM_CH-1:0] oe_n,
    output logic [NUM_CH-1:0] drv_en,
    output logic [NUM_CH-1:0] data_valid,
    output logic [NUM_CH-1:0] zero_force
);
    import adc_pwr_pkg::*;

    logic      armed;
    ch_state_e ch_state [NUM_CH];

    adc_pwr_arm u_arm (
        .clk   (clk),
        .rst   (rst),
        .pd_n  (pd_n),
        .armed (armed)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        adc_pwr_chan #(
            .COLD_CYC (COLD_CYC),
            .WARM_CYC (WARM_CYC),
            .PIPE_CYC (PIPE_CYC)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .pd_n       (pd_n),
            .armed      (armed),
            .want       (slp_n[g]),
            .state      (ch_state[g]),
            .valid      (data_valid[g]),
            .zero_force (zero_force[g])
        );
    end

    // Pad enables follow the active-low enable inputs in every state.
    always_comb drv_en = ~oe_n;

    AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (data_valid == '0 && zero_force == '1)); // R8
    AST_PD_CLAMPS_ALL: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> (data_valid == '0 && zero_force == '1)); // R1
endmodule

// File: tb/adc_pwr_seq_tb.sv
`timescale 1ns/1ps
module adc_pwr_seq_tb;
    localparam int NCH    = 2;
    localparam int T_COLD = 900 + 12;
    localparam int T_WARM = 20 + 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           pd_n = 1'b1;
    logic [NCH-1:0] slp_n = 2'b11;
    logic [NCH-1:0] oe_n = 2'b00;
    logic [NCH-1:0] drv_en, data_valid, zero_force;

    always #5 clk = ~clk;

    adc_pwr_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .pd_n       (pd_n),
        .slp_n      (slp_n),
        .oe_n       (oe_n),
        .drv_en     (drv_en),
        .data_valid (data_valid),
        .zero_force (zero_force)
    );

    // Behavioural model: mode 0 down, 1 idle, 2 waking, 3 running.
    int     m_mode [NCH];
    longint m_due  [NCH];
    bit     m_cold [NCH];
    bit     m_armed;
    longint cyc = 0;
    bit     started = 0;
    bit     done = 0;
    int     n_cmp = 0;
    int     n_bad = 0;
    string  req = "R8";

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_mode[i] = 0; m_cold[i] = 1; m_due[i] = 0;
            end
            m_armed = 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (!pd_n) begin
                    m_mode[i] = 0; m_cold[i] = 1;
                end else if (!m_armed) begin
                    m_mode[i] = 0;
                end else if (m_mode[i] <= 1) begin
                    if (slp_n[i]) begin
                        m_mode[i] = 2;
                        m_due[i]  = cyc + (m_cold[i] ? T_COLD : T_WARM);
                    end else begin
                        m_mode[i] = 1;
                    end
                end else if (m_mode[i] == 2) begin
                    if (!slp_n[i]) m_mode[i] = 1;
                    else if (cyc == m_due[i]) begin
                        m_mode[i] = 3; m_cold[i] = 0;
                    end
                end else begin
                    if (!slp_n[i]) m_mode[i] = 1;
                end
            end
            if (!pd_n) m_armed = 1;
        end
    end

    task automatic chk(string what, int ch, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s ch%0d at cycle %0d: actual %b expected %b",
                     req, what, ch, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            for (int i = 0; i < NCH; i++) begin
                chk("data_valid", i, data_valid[i], m_mode[i] == 3);
                chk("zero_force", i, zero_force[i], m_mode[i] == 0);
                chk("drv_en",     i, drv_en[i],     !oe_n[i]);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200_000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // Reset state, then R8: unarmed, run requested, nothing leaves down.
        tick(3);
        rst = 1'b0;
        req = "R8";
        tick(20);

        // R1: power-down with both run requests high.
        req = "R1";
        pd_n = 1'b0;
        tick(3);

        // R4 cold wake ch0; R2/R3 ch1 sleeps (slp_n=01), zero_force low.
        req = "R4";
        pd_n = 1'b1; slp_n = 2'b01;
        tick(T_COLD + 10);

        // R6 ch1 still cold after sleeping; R9 ch0 stays valid.
        req = "R6";
        slp_n = 2'b11;
        tick(T_COLD + 10);

        // R11: stop ch0 while running.
        req = "R11";
        slp_n = 2'b10;
        tick(5);

        // R5: warm wake ch0.
        req = "R5";
        slp_n = 2'b11;
        tick(T_WARM + 6);

        // R7: abort ch0 during a warm wake, then restart in full.
        req = "R7";
        slp_n = 2'b10; tick(3);
        slp_n = 2'b11; tick(10);
        slp_n = 2'b10; tick(1);
        slp_n = 2'b11; tick(T_WARM + 6);

        // R10: enables follow oe_n in all patterns.
        req = "R10";
        oe_n = 2'b01; tick(2);
        oe_n = 2'b10; tick(2);
        oe_n = 2'b11; pd_n = 1'b0; tick(2);
        pd_n = 1'b1; oe_n = 2'b00; slp_n = 2'b00; tick(4);

        // R3: both sleep, then both run (cold after power-down above).
        req = "R3";
        slp_n = 2'b11;
        tick(T_COLD + 6);
        slp_n = 2'b00; tick(3);
        req = "R9";
        slp_n = 2'b11; tick(T_WARM + 4);

        // R1 in mid-wake, then R6 cold restart.
        req = "R1";
        slp_n = 2'b01; tick(3);
        slp_n = 2'b11; tick(10);
        pd_n = 1'b0; tick(2);
        req = "R6";
        pd_n = 1'b1;
        tick(T_COLD + 6);

        finish_run();
    end
endmodule